// File: doc/BRIEF.md
# Windowed Nine-Sample Multiply-Accumulate

This block runs a multiply-accumulate over a continuous stream. On each rising clock edge it multiplies a signed data sample by a signed coefficient and folds the product into a running sum. The stream is cut into windows of nine consecutive products. When a window is complete, the block raises a one-cycle strobe and presents the finished sum together with a write address. An external memory or a downstream consumer can capture the result in that cycle. The next window starts on the following edge, so no sample is ever dropped between windows.

The block stores no history. Each result must be taken in the cycle its strobe is high. The window phase comes from a small counter. On the edge that closes a window, the sum register is reloaded with the current product rather than cleared. The strobe is registered from the phase just before the last one, so it lines up with the finished sum. The asynchronous reset input is active low. It asserts at once and is released through a two-stage synchronizer.

Top module: `mac_window_acc`

## Requirements
- R1: While `rst_n` is low, `result`, `result_valid` and `wr_addr` are all zero, and asserting `rst_n` clears them without waiting for a clock edge.
- R2: The window phase counts 0 to 8 and wraps to 0, so after the first window `result_valid` pulses exactly once every nine cycles.
- R3: Each product is the signed 5-bit `data_in` times the signed 3-bit `coef_in` (two's complement), both sign-extended to 8 bits. This holds at the extreme operand values, for example -16 times -4 gives 64 and 15 times -4 gives -60.
- R4: On the edge at phase 8, the sum is loaded with that edge's product alone and the old sum is discarded. Every window after the first therefore sums exactly nine consecutive samples, the samples at phases 8, 0, 1, ..., 7.
- R5: `result_valid` is high for exactly one cycle, the cycle right after the edge that captured the phase-7 sample, and in that cycle `result` holds the finished window sum.
- R6: `wr_addr` starts at zero and increments by one, modulo 2^ADDR_W, on each phase-8 edge. While `result_valid` is high it therefore equals the index of the window being presented.
- R7: The first window after reset starts from a zero sum at phase 0, so it contains only the eight samples at phases 0 to 7.
- R8: Between strobes, `result` shows the partial sum of the current window so far.
- R9: After `rst_n` is released, the first sample taken into a sum is the one present at the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously inside the block |
| data_in | input | DATA_W (5) | Signed data sample |
| coef_in | input | COEF_W (3) | Signed coefficient |
| result | output | SUM_W (12) | Running or finished window sum, signed |
| result_valid | output | 1 | One-cycle strobe marking a finished window sum |
| wr_addr | output | ADDR_W (8) | Write address of the presented window |

## Verification
The bench sweeps every pair of data and coefficient values, repeating the sweep long enough for the write address to wrap. It compares the sum, strobe and address on every cycle against a model built from the rules above.

It targets these corner cases, and what a wrong design would do in each:
- The reload on the closing edge: a design that cleared the sum there would drop one sample per window, and its totals would come out short.
- The short first window: a design that miscounted it would misalign every later window.
- Runs of extreme products: a design that lost the sign extension would give wrong totals.
- Strobe timing: a strobe one cycle off would show a partial sum or the next window's opening product.
- A reset asserted mid-window, away from any clock edge: it checks that clearing is immediate and that the phase restarts cleanly.

// File: rtl/mac9_pkg.sv
package mac9_pkg;

  localparam int unsigned DEF_DATA_W = 5;
  localparam int unsigned DEF_COEF_W = 3;
  localparam int unsigned DEF_WINDOW = 9;
  localparam int unsigned DEF_ADDR_W = 8;

  // Width needed to hold a phase index 0..n-1 (at least one bit)
  function automatic int unsigned idx_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int unsigned DATA_W = 5,
  parameter int unsigned COEF_W = 3,
  parameter int unsigned PROD_W = DATA_W + COEF_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic [PROD_W-1:0] prod_o
);

  localparam int unsigned DPAD = PROD_W - DATA_W;
  localparam int unsigned CPAD = PROD_W - COEF_W;

  logic signed [PROD_W-1:0] data_ext;
  logic signed [PROD_W-1:0] coef_ext;
  logic signed [PROD_W-1:0] prod_full;

  // Both operands widened with their sign bit before the multiply (R3)
  always_comb begin
    data_ext  = {{DPAD{data_i[DATA_W-1]}}, data_i};
    coef_ext  = {{CPAD{coef_i[COEF_W-1]}}, coef_i};
    prod_full = data_ext * coef_ext;
  end

  assign prod_o = prod_full;

endmodule

// File: rtl/mac_phase_ctr.sv
module mac_phase_ctr #(
  parameter int unsigned WINDOW = 9,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [CNT_W-1:0]  phase_o,
  output logic              close_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(WINDOW - 1);
  localparam logic [CNT_W-1:0] PRE_PH  = CNT_W'(WINDOW - 2);

  logic [CNT_W-1:0]  phase_q, phase_d;
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q,  addr_d;
  logic              close_w;

  // Next-state logic
  always_comb begin
    close_w = (phase_q == LAST_PH);
    phase_d = close_w ? '0 : phase_q + 1'b1;
    valid_d = (phase_q == PRE_PH);
    addr_d  = close_w ? addr_q + 1'b1 : addr_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      phase_q <= phase_d;
      valid_q <= valid_d;
      addr_q  <= addr_d;
    end
  end

  assign phase_o = phase_q;
  assign close_o = close_w;
  assign valid_o = valid_q;
  assign addr_o  = addr_q;

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST_PH); // R2
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == LAST_PH) |=> (phase_q == '0)); // R2
  AST_STROBE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PRE_PH) |=> valid_q); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == LAST_PH) |=> (addr_q == $past(addr_q) + 1'b1)); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != LAST_PH) |=> $stable(addr_q)); // R6

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int unsigned PROD_W = 8,
  parameter int unsigned SUM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic [SUM_W-1:0]  sum_o
);

  localparam int unsigned SPAD = SUM_W - PROD_W;

  logic [SUM_W-1:0] sum_q, sum_d;
  logic [SUM_W-1:0] prod_ext;

  // Closing edge reloads with the current product, otherwise accumulate (R4)
  always_comb begin
    prod_ext = {{SPAD{prod_i[PROD_W-1]}}, prod_i};
    sum_d    = restart_i ? prod_ext : sum_q + prod_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign sum_o = sum_q;

  AST_RELOAD_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (sum_q == {{SPAD{$past(prod_i[PROD_W-1])}}, $past(prod_i)})); // R4

endmodule

// File: rtl/mac_window_acc.sv
module mac_window_acc #(
  parameter int unsigned DATA_W = mac9_pkg::DEF_DATA_W,
  parameter int unsigned COEF_W = mac9_pkg::DEF_COEF_W,
  parameter int unsigned WINDOW = mac9_pkg::DEF_WINDOW,
  parameter int unsigned ADDR_W = mac9_pkg::DEF_ADDR_W,
  localparam int unsigned PROD_W = DATA_W + COEF_W,
  localparam int unsigned CNT_W  = mac9_pkg::idx_width(WINDOW),
  localparam int unsigned SUM_W  = PROD_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_in,
  input  logic [COEF_W-1:0] coef_in,
  output logic [SUM_W-1:0]  result,
  output logic              result_valid,
  output logic [ADDR_W-1:0] wr_addr
);

  logic              rst_core_n;
  logic [PROD_W-1:0] prod;
  logic [CNT_W-1:0]  phase;
  logic              close_win;

  mac_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  mac_mult #(.DATA_W(DATA_W), .COEF_W(COEF_W), .PROD_W(PROD_W)) u_mult (
    .data_i (data_in),
    .coef_i (coef_in),
    .prod_o (prod)
  );

  mac_phase_ctr #(.WINDOW(WINDOW), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .phase_o (phase),
    .close_o (close_win),
    .valid_o (result_valid),
    .addr_o  (wr_addr)
  );

  mac_accum #(.PROD_W(PROD_W), .SUM_W(SUM_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .restart_i (close_win),
    .prod_i    (prod),
    .sum_o     (result)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (!result_valid && result == '0 && wr_addr == '0)); // R1
  AST_FIRST_PHASE: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> (phase == '0)); // R9

endmodule

// File: tb/tb_mac_window_acc.sv
module tb_mac_window_acc;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 8;
  localparam int AMASK  = (1 << ADDR_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  data_in;
  logic [2:0]  coef_in;
  logic [11:0] result;
  logic        result_valid;
  logic [7:0]  wr_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int exp_sum, exp_addr, exp_valid, ph, gap;
  bit first_win;

  always #(CLK_P/2) clk = ~clk;

  mac_window_acc dut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .coef_in(coef_in),
    .result(result), .result_valid(result_valid), .wr_addr(wr_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    exp_sum = 0; exp_addr = 0; exp_valid = 0; ph = 0; gap = 0;
    first_win = 1'b1;
  endtask

  // Release at a falling edge, then skip two rising edges (R9)
  task automatic release_reset();
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int sval5(input logic [4:0] v); return int'($signed(v)); endfunction
  function automatic int sval3(input logic [2:0] v); return int'($signed(v)); endfunction

  task automatic run(input int n, input int mode, input string wtag);
    for (int j = 0; j < n; j++) begin
      logic [4:0] d;
      logic [2:0] c;
      int p;
      // Outputs reflect every edge up to the previous one
      chk("R5 strobe", int'(result_valid), exp_valid);
      chk("R6 address", int'(wr_addr), exp_addr);
      if (exp_valid != 0) begin
        if (first_win) chk("R7 R9 first window sum", int'($signed(result)), exp_sum);
        else begin
          chk(wtag, int'($signed(result)), exp_sum);
          chk("R2 strobe spacing", gap, 9);
        end
        gap = 0;
      end else begin
        chk("R8 partial sum", int'($signed(result)), exp_sum);
      end
      gap++;
      case (mode)
        0: begin d = 5'(j);        c = 3'(j >> 5); end
        1: begin d = 5'b10000;     c = 3'b100;     end
        2: begin d = 5'b01111;     c = 3'b100;     end
        default: begin d = 5'(j*7 + 3); c = 3'(j*5 + 1); end
      endcase
      data_in = d;
      coef_in = c;
      p = sval5(d) * sval3(c);
      if (ph == 8) begin
        exp_sum   = p;
        exp_addr  = (exp_addr + 1) & AMASK;
        first_win = 1'b0;
      end else begin
        exp_sum = exp_sum + p;
      end
      exp_valid = (ph == 7) ? 1 : 0;
      ph = (ph + 1) % 9;
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n   = 1'b0;
    data_in = 5'd9;
    coef_in = 3'd3;
    repeat (3) @(negedge clk);
    chk("R1 reset strobe", int'(result_valid), 0);
    chk("R1 reset address", int'(wr_addr), 0);
    chk("R1 reset sum", int'(result), 0);
    model_reset();
    release_reset();
    // Full operand sweep, long enough for the address to wrap
    run(2400, 0, "R4 nine-sample window");
    // Extreme products
    run(40, 1, "R3 product -16 x -4");
    run(40, 2, "R3 product 15 x -4");
    // Reset asserted mid-window, away from an edge
    #(CLK_P/4);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear strobe", int'(result_valid), 0);
    chk("R1 async clear address", int'(wr_addr), 0);
    chk("R1 async clear sum", int'(result), 0);
    @(negedge clk);
    model_reset();
    release_reset();
    run(60, 3, "R4 window after reset");
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule